// File: doc/BRIEF.md
# Bit-interleaved parity nibble generator/checker

This block protects the payload of a fixed-length serial frame with a 4-bit column parity. Each frame arrives one bit per qualified clock cycle, with a start-of-frame marker on its first bit and an overhead mask that flags framing and service bits. Only payload bits take part. Each payload bit is folded into one of four parity columns, chosen by its place inside its payload nibble. The final four bit positions of every frame are reserved for the parity nibble.

The block has two independent lanes that share the clock, the enable and the frame-size select. The transmit lane forwards its stream one cycle later and writes the computed parity over the frame's last four bits. The receive lane computes the same parity over the incoming payload and compares it with the last four bits it receives. It raises a single-cycle error pulse if any column disagrees. Frame alignment and the generation of the mask are done upstream, so the marker and the mask are plain inputs.

Top module: `bip4_nibble_par`

## Requirements
- R1: Payload bits are counted from zero at each frame start. Payload bit number n goes into column 3 - (n mod 4), so the first payload bit of each nibble lands in column 3. On the line the parity nibble is sent column 3 first and column 0 last.
- R2: The transmit output repeats the transmit input with one cycle of latency. `tx_out_vld` and `tx_out_sof` follow `tx_vld` and `tx_vld & tx_sof`. With the enable high, the last four bits of each frame are replaced by the computed parity and all other bits pass unchanged.
- R3: On receive, a mismatch in one or more columns makes `rx_err` high for exactly one cycle. That cycle is the one right after the clock edge that accepts the frame's last bit.
- R4: A received frame whose last nibble equals the parity of its own payload raises no error.
- R5: Bits flagged by the overhead mask never change any parity column.
- R6: With `par_en` low the last nibble is passed on as ordinary data and `rx_err` stays low.
- R7: The columns clear at every frame-start marker, so the parity of a frame depends only on that frame's payload.
- R8: `mode` 2'b00 and 2'b01 select a frame of FLEN_SHORT bits (default 848). `mode` 2'b10 and 2'b11 select FLEN_LONG bits (default 1536). Both lengths must be multiples of 4.
- R9: Synchronous reset clears all outputs. After reset a lane inserts and checks nothing until it has seen a frame-start marker, so a partial frame raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| par_en | input | 1 | Parity insertion and checking enable |
| mode | input | 2 | Frame size select (see R8) |
| tx_vld | input | 1 | Transmit bit strobe |
| tx_sof | input | 1 | Transmit first bit of frame |
| tx_oh | input | 1 | Transmit bit is overhead |
| tx_din | input | 1 | Transmit data bit |
| tx_out_vld | output | 1 | Registered transmit strobe |
| tx_out_sof | output | 1 | Registered transmit frame start |
| tx_dout | output | 1 | Transmit bit with parity inserted |
| rx_vld | input | 1 | Receive bit strobe |
| rx_sof | input | 1 | Receive first bit of frame |
| rx_oh | input | 1 | Receive bit is overhead |
| rx_din | input | 1 | Receive data bit |
| rx_err | output | 1 | One-cycle parity mismatch pulse |

## Verification
The hardest case to reach is the error pulse's exact timing. Idle strobe gaps between bits must not move it, and it must appear only for a frame that began with a marker. The bench feeds identical frames into both lanes. It ties each error pulse to the sample taken right after the last bit is driven, and inserts idle gaps in some frames so the pulse is tracked by bit and not by cycle count. Frames are also sent without a marker right after reset. Other frames follow a junk frame, to show that no state carries over between frames.

// File: rtl/bip4_pkg.sv
`timescale 1ns/1ps
package bip4_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;

  // first bit of a nibble (phase 0) belongs to column 3
  function automatic logic [1:0] col_of(input logic [1:0] phase);
    return ~phase;
  endfunction
endpackage

// File: rtl/bip4_frame_pos.sv
`timescale 1ns/1ps
module bip4_frame_pos
  import bip4_pkg::*;
#(
  parameter int FLEN_SHORT = 848,
  parameter int FLEN_LONG  = 1536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vld,
  input  logic       sof,
  input  logic       long_sel,
  output logic       in_tail,
  output logic [1:0] tail_col,
  output logic       is_last
);
  localparam int POS_W = $clog2(FLEN_LONG) + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] LEN_S = POS_W'(FLEN_SHORT);
  localparam logic [POS_W-1:0] LEN_L = POS_W'(FLEN_LONG);

  logic [POS_W-1:0] pos_q, cur_pos, flen;

  // position of the bit on the input now; parks at POS_MAX until a marker
  always_comb begin
    if (sof)                 cur_pos = '0;
    else if (pos_q == POS_MAX) cur_pos = POS_MAX;
    else                     cur_pos = pos_q + POS_W'(1);
    flen     = long_sel ? LEN_L : LEN_S;
    in_tail  = (cur_pos >= flen - POS_W'(4)) && (cur_pos < flen);
    is_last  = (cur_pos == flen - POS_W'(1));
    // frame lengths are multiples of 4, so the low bits give the tail phase
    tail_col = col_of(cur_pos[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)      pos_q <= POS_MAX;
    else if (vld) pos_q <= cur_pos;
  end

  // R7: a marker restarts the position count
  a_r7_sof_restarts: assert property (@(posedge clk) disable iff (rst)
    (vld && sof) |=> (pos_q == '0));
endmodule

// File: rtl/bip4_col_acc.sv
`timescale 1ns/1ps
module bip4_col_acc
  import bip4_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic sof,
  input  logic take,
  input  logic din,
  output nib_t acc_q
);
  logic [1:0] ph_q, ph_base, col;
  nib_t       acc_n;

  always_comb begin
    ph_base = sof ? 2'd0 : ph_q;
    col     = col_of(ph_base);
  end

  for (genvar k = 0; k < NIB_W; k++) begin : g_col
    assign acc_n[k] = (sof ? 1'b0 : acc_q[k]) ^ (take && din && (col == 2'(k)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ph_q  <= 2'd0;
    end else if (vld) begin
      acc_q <= acc_n;
      ph_q  <= take ? ph_base + 2'd1 : ph_base;
    end
  end

  // R7: a marker on a non-payload bit leaves all columns clear
  a_r7_clear_on_sof: assert property (@(posedge clk) disable iff (rst)
    (vld && sof && !take) |=> (acc_q == '0));
  // R5: a bit that is not taken (overhead) leaves the columns unchanged
  a_r5_skip_holds: assert property (@(posedge clk) disable iff (rst)
    (!sof && !take) |=> $stable(acc_q));
endmodule

// File: rtl/bip4_lane.sv
`timescale 1ns/1ps
module bip4_lane
  import bip4_pkg::*;
#(
  parameter int FLEN_SHORT = 848,
  parameter int FLEN_LONG  = 1536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       par_en,
  input  logic       long_sel,
  input  logic       vld,
  input  logic       sof,
  input  logic       oh,
  input  logic       din,
  output nib_t       acc_q,
  output logic       in_tail,
  output logic [1:0] tail_col,
  output logic       is_last
);
  logic take;

  bip4_frame_pos #(.FLEN_SHORT(FLEN_SHORT), .FLEN_LONG(FLEN_LONG)) u_pos (
    .clk(clk), .rst(rst), .vld(vld), .sof(sof), .long_sel(long_sel),
    .in_tail(in_tail), .tail_col(tail_col), .is_last(is_last)
  );

  // payload only: overhead and the reserved parity nibble are skipped
  assign take = vld && !oh && !(par_en && in_tail);

  bip4_col_acc u_acc (
    .clk(clk), .rst(rst), .vld(vld), .sof(sof), .take(take), .din(din),
    .acc_q(acc_q)
  );
endmodule

// File: rtl/bip4_nibble_par.sv
`timescale 1ns/1ps
module bip4_nibble_par
  import bip4_pkg::*;
#(
  parameter int FLEN_SHORT = 848,
  parameter int FLEN_LONG  = 1536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       par_en,
  input  logic [1:0] mode,
  input  logic       tx_vld,
  input  logic       tx_sof,
  input  logic       tx_oh,
  input  logic       tx_din,
  output logic       tx_out_vld,
  output logic       tx_out_sof,
  output logic       tx_dout,
  input  logic       rx_vld,
  input  logic       rx_sof,
  input  logic       rx_oh,
  input  logic       rx_din,
  output logic       rx_err
);
  localparam int LANES = 2;
  localparam int TXL   = 0;
  localparam int RXL   = 1;

  logic             long_sel;
  logic [LANES-1:0] l_vld, l_sof, l_oh, l_din, l_tail, l_last;
  logic [1:0]       l_col [LANES];
  nib_t             l_acc [LANES];
  logic [2:0]       cap_q;
  nib_t             rx_seen;

  assign long_sel = (mode == 2'b10) || (mode == 2'b11);
  assign l_vld = {rx_vld, tx_vld};
  assign l_sof = {rx_sof, tx_sof};
  assign l_oh  = {rx_oh,  tx_oh};
  assign l_din = {rx_din, tx_din};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bip4_lane #(.FLEN_SHORT(FLEN_SHORT), .FLEN_LONG(FLEN_LONG)) u_lane (
      .clk(clk), .rst(rst), .par_en(par_en), .long_sel(long_sel),
      .vld(l_vld[g]), .sof(l_sof[g]), .oh(l_oh[g]), .din(l_din[g]),
      .acc_q(l_acc[g]), .in_tail(l_tail[g]), .tail_col(l_col[g]),
      .is_last(l_last[g])
    );
  end

  // transmit: forward, with the parity column written over the tail
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out_vld <= 1'b0;
      tx_out_sof <= 1'b0;
      tx_dout    <= 1'b0;
    end else begin
      tx_out_vld <= tx_vld;
      tx_out_sof <= tx_vld && tx_sof;
      if (tx_vld && par_en && l_tail[TXL]) tx_dout <= l_acc[TXL][l_col[TXL]];
      else                                 tx_dout <= tx_din;
    end
  end

  // receive: gather the tail first-bit-first, compare on the last bit
  assign rx_seen = {cap_q, rx_din};

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      rx_err <= 1'b0;
    end else begin
      if (rx_vld && l_tail[RXL]) cap_q <= {cap_q[1:0], rx_din};
      rx_err <= rx_vld && par_en && l_last[RXL] && (rx_seen != l_acc[RXL]);
    end
  end

  // R3: an error pulse only follows an accepted receive bit
  a_r3_err_after_bit: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> $past(rx_vld));
  // R3: the pulse lasts one cycle
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> !rx_err);
  // R6: no error while parity is disabled
  a_r6_off_no_err: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> $past(par_en));
  // R6: disabled transmit passes every bit through
  a_r6_off_pass: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && !par_en) |=> (tx_dout == $past(tx_din)));
  // R2: strobe is forwarded one cycle later
  a_r2_vld_follow: assert property (@(posedge clk) disable iff (rst)
    tx_vld |=> tx_out_vld);
  // R1: the last bit of a frame closes the tail with column 0
  a_r1_last_col0: assert property (@(posedge clk) disable iff (rst)
    (rx_vld && l_last[RXL]) |-> (l_col[RXL] == 2'd0));
  // R8: the last bit of a transmit frame lies inside its tail
  a_r8_last_in_tail: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && l_last[TXL]) |-> l_tail[TXL]);
endmodule

// File: tb/tb_bip4_nibble_par.sv
`timescale 1ns/1ps
module tb_bip4_nibble_par;
  localparam int SHORT = 848;
  localparam int LONG  = 1536;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1, par_en = 1'b1;
  logic [1:0] mode = 2'b00;
  logic tx_vld = 0, tx_sof = 0, tx_oh = 0, tx_din = 0;
  logic rx_vld = 0, rx_sof = 0, rx_oh = 0, rx_din = 0;
  logic tx_out_vld, tx_out_sof, tx_dout, rx_err;

  bip4_nibble_par #(.FLEN_SHORT(SHORT), .FLEN_LONG(LONG)) dut (
    .clk(clk), .rst(rst), .par_en(par_en), .mode(mode),
    .tx_vld(tx_vld), .tx_sof(tx_sof), .tx_oh(tx_oh), .tx_din(tx_din),
    .tx_out_vld(tx_out_vld), .tx_out_sof(tx_out_sof), .tx_dout(tx_dout),
    .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_oh(rx_oh), .rx_din(rx_din),
    .rx_err(rx_err)
  );

  bit fb [LONG];
  bit fm [LONG];
  bit ob [LONG];
  int oc, errs, total, bad;
  bit err_ok;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input int len);
    logic [3:0] p = 4'd0;
    int ph = 0;
    for (int i = 0; i < len - 4; i++) begin
      if (!fm[i]) begin
        p[3 - ph] = p[3 - ph] ^ fb[i];
        ph = (ph + 1) % 4;
      end
    end
    return p;
  endfunction

  task automatic build(input int len);
    for (int i = 0; i < LONG; i++) begin
      fb[i] = 1'($urandom_range(0, 1));
      fm[i] = (i < 12) || (i >= 212 && (i % 212) < 4);
      if (i >= len - 4) fm[i] = 1'b0;
    end
  endtask

  task automatic set_tail(input int len, input logic [3:0] p);
    for (int j = 0; j < 4; j++) fb[len - 4 + j] = p[3 - j];
  endtask

  function automatic logic [3:0] out_tail(input int len);
    return {ob[len-4], ob[len-3], ob[len-2], ob[len-1]};
  endfunction

  function automatic logic [3:0] in_tail(input int len);
    return {fb[len-4], fb[len-3], fb[len-2], fb[len-1]};
  endfunction

  task automatic idle();
    tx_vld = 0; rx_vld = 0; tx_sof = 0; rx_sof = 0;
  endtask

  task automatic sample(input bit just_last);
    if (tx_out_vld) begin
      if (oc < LONG) ob[oc] = tx_dout;
      oc++;
    end
    if (rx_err) begin
      errs++;
      if (just_last) err_ok = 1;
    end
  endtask

  task automatic drive(input int len, input bit with_sof, input int gap);
    bit last = 0;
    oc = 0; errs = 0; err_ok = 0;
    for (int i = 0; i < len; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk); sample(last); last = 0; idle();
      end
      @(negedge clk); sample(last);
      tx_vld = 1; rx_vld = 1;
      tx_sof = with_sof && (i == 0); rx_sof = with_sof && (i == 0);
      tx_oh = fm[i]; rx_oh = fm[i];
      tx_din = fb[i]; rx_din = fb[i];
      last = (i == len - 1);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sample(last); last = 0; idle();
    end
  endtask

  function automatic int body_mism(input int len);
    int m = 0;
    for (int i = 0; i < len - 4; i++) if (ob[i] != fb[i]) m++;
    return m;
  endfunction

  task automatic t_reset();
    rst = 1; repeat (3) @(negedge clk);
    chk(rx_err == 0, "R9", "rx_err in reset", int'(rx_err), 0);
    chk(tx_out_vld == 0, "R9", "tx_out_vld in reset", int'(tx_out_vld), 0);
    chk(tx_dout == 0, "R9", "tx_dout in reset", int'(tx_dout), 0);
    rst = 0;
  endtask

  task automatic t_no_marker();
    logic [3:0] p;
    mode = 2'b00; par_en = 1; build(SHORT); p = model(SHORT); set_tail(SHORT, ~p);
    drive(SHORT, 0, 0);
    chk(errs == 0, "R9", "errors before first marker", errs, 0);
  endtask

  task automatic t_good(input logic [1:0] m, input int len, input int gap, input string req);
    logic [3:0] p;
    mode = m; par_en = 1; build(len); p = model(len); set_tail(len, p);
    drive(len, 1, gap);
    chk(errs == 0, "R4", "errors on matching frame", errs, 0);
    chk(oc == len, req, "forwarded bit count", oc, len);
    chk(body_mism(len) == 0, "R2", "payload passthrough mismatches", body_mism(len), 0);
    chk(out_tail(len) == p, "R1", "inserted parity", int'(out_tail(len)), int'(p));
  endtask

  task automatic t_all_bad();
    logic [3:0] p;
    mode = 2'b00; par_en = 1; build(SHORT); p = model(SHORT); set_tail(SHORT, ~p);
    drive(SHORT, 1, 0);
    chk(errs == 1, "R3", "pulse count all columns bad", errs, 1);
    chk(err_ok == 1, "R3", "pulse right after last bit", int'(err_ok), 1);
    chk(out_tail(SHORT) == p, "R2", "parity overwrites tail", int'(out_tail(SHORT)), int'(p));
  endtask

  task automatic t_one_col_long();
    logic [3:0] p;
    mode = 2'b10; par_en = 1; build(LONG); p = model(LONG); set_tail(LONG, p);
    fb[LONG-2] = ~fb[LONG-2];
    drive(LONG, 1, 7);
    chk(errs == 1, "R3", "pulse count one column bad", errs, 1);
    chk(err_ok == 1, "R8", "pulse after bit 1535 with gaps", int'(err_ok), 1);
    chk(out_tail(LONG) == p, "R8", "long frame parity", int'(out_tail(LONG)), int'(p));
  endtask

  task automatic t_overhead();
    logic [3:0] p;
    mode = 2'b00; par_en = 1; build(SHORT); p = model(SHORT); set_tail(SHORT, p);
    for (int i = 0; i < SHORT; i++) if (fm[i]) fb[i] = ~fb[i];
    drive(SHORT, 1, 0);
    chk(errs == 0, "R5", "errors after overhead flips", errs, 0);
    chk(out_tail(SHORT) == p, "R5", "parity after overhead flips", int'(out_tail(SHORT)), int'(p));
  endtask

  task automatic t_disabled();
    logic [3:0] p;
    mode = 2'b00; par_en = 0; build(SHORT); p = model(SHORT); set_tail(SHORT, ~p);
    drive(SHORT, 1, 0);
    chk(errs == 0, "R6", "errors while disabled", errs, 0);
    chk(out_tail(SHORT) == in_tail(SHORT), "R6", "tail passthrough",
        int'(out_tail(SHORT)), int'(in_tail(SHORT)));
    par_en = 1;
  endtask

  task automatic t_clear();
    logic [3:0] p;
    mode = 2'b00; par_en = 1; build(SHORT);
    for (int i = 0; i < SHORT; i++) fb[i] = 1'b1;
    drive(SHORT, 1, 0);
    build(SHORT); p = model(SHORT); set_tail(SHORT, p);
    drive(SHORT, 1, 0);
    chk(errs == 0, "R7", "errors on frame after junk", errs, 0);
    chk(out_tail(SHORT) == p, "R7", "parity of own frame only", int'(out_tail(SHORT)), int'(p));
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    t_reset();
    t_no_marker();
    t_good(2'b00, SHORT, 0, "R8");
    t_all_bad();
    t_one_col_long();
    t_good(2'b11, LONG, 5, "R8");
    t_good(2'b01, SHORT, 3, "R8");
    t_overhead();
    t_disabled();
    t_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule